// File: doc/BRIEF.md
# Interval-Based Core Self-Test Sequencer

This block runs a logic self-test on a processor core as a series of programmable test intervals. Software first sets how many intervals to run and how many cycles the whole run may take. It then starts the run by writing a start key into the control register. The sequencer starts each interval in turn on a pattern engine. The engine is modelled here as a start/done handshake that returns one pass bit per interval.

Every run ends with a fixed-length reset request to the core under test, whether the run passed, failed or timed out. The result is kept in a status register that only the power-on reset clears. After the core comes out of the self-test reset, its reset handler can read whether any interval failed, which interval failed first, and whether the run timed out.

Configuration is frozen for the whole run, including the reset phase. Reads are always served.

Top module: `selftest_ctrl`

## Requirements
- R1: After power-on reset (porRstN low), all four registers read zero, and patStart and coreRstReq are low.
- R2: A write to address 0 whose bits [3:0] equal 0xA starts a run when the block is idle. Any other value leaves the block idle: no patStart, and status bit 3 stays 0.
- R3: Address 0 reads back the last key written, in bits [3:0]. Address 1 holds the interval count in bits [4:0]. Address 2 holds the timeout in cycles in bits [15:0].
- R4: For a count N greater than 0, the run issues exactly N one-cycle patStart pulses, with patIdx running 0, 1, ... N-1. Each pulse after the first comes in the cycle after the patDone of the previous interval. With N equal to 0, no pulse is issued and the run ends as a pass.
- R5: The first interval whose patDone comes with patPass low sets status bit 1 and writes its index into status bits [12:8]. Later failures in the same run change neither.
- R6: If the run spends the programmed number of cycles (at least 1) in its interval phase without finishing, it ends with status bits 1 and 2 set and bit 0 clear.
- R7: Every run ends with coreRstReq high for exactly 8 consecutive cycles. After that the block is idle, and status bit 3 reads 0.
- R8: Finishing all intervals sets status bit 0. Status bit 3 reads 1 while a run is active. Starting a run clears status bits 0, 1, 2 and the index field. Otherwise the status holds through coreRstReq until the next start or power-on reset.
- R9: Register writes made while status bit 3 is set have no effect. Reads keep working during a run.
- R10: If the last interval completes in the same cycle in which the timeout expires, the run is recorded as complete and not as timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous; the only reset that clears status |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address (0 control, 1 count, 2 timeout, 3 status) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| patStart | output | 1 | One-cycle start of a test interval on the pattern engine |
| patIdx | output | 5 | Index of the current interval |
| patDone | input | 1 | Pattern engine finished the interval |
| patPass | input | 1 | Signature of the finished interval matched; valid with patDone |
| coreRstReq | output | 1 | Reset request to the core under test |

## Verification
A wrong sequencer state appears at the ports within one cycle. A stray or missing patStart, a wrong patIdx, or a coreRstReq pulse of the wrong length is visible on the next clock. Status bit 3 also shows whether the block believes a run is active. A wrong latch of the failing index or the timeout flag stays hidden until the status register is read after the run. For that reason the bench keeps address 3 selected while it waits, and compares the read data against its own model on every cycle. A wrong elapsed-cycle count shifts the end of the run by whole cycles, so the test cases sit exactly at the timeout boundary.

// File: rtl/stc_pkg.sv
`timescale 1ns/1ps
package stc_pkg;

  // Register addresses. Software-visible, so they are fixed.
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_TMO  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // Bit positions inside the status word.
  localparam int ST_CMP_BIT  = 0;
  localparam int ST_FAIL_BIT = 1;
  localparam int ST_TO_BIT   = 2;
  localparam int ST_BUSY_BIT = 3;
  localparam int ST_IDX_LSB  = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_RESET  = 2'd3
  } stcState_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic startRun;     // clear the status, the index and the counters
    logic runTick;      // one more cycle spent in the interval phase
    logic advance;      // step to the next interval
    logic latchFail;    // interval reported a mismatch
    logic setComplete;  // all intervals finished
    logic setTimeout;   // time budget used up
    logic rstTick;      // one more cycle of reset request
  } stcStrobe_t;

endpackage

// File: rtl/stc_datapath.sv
`timescale 1ns/1ps
module stc_datapath
  import stc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int TMO_W     = 16,
  parameter int RST_LEN   = 8,
  parameter logic [3:0] START_KEY = 4'hA
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              busWrEn,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              busy,
  input  stcStrobe_t        strobe,
  output logic              keyHit,
  output logic              countZero,
  output logic              lastIdx,
  output logic              tmoHit,
  output logic              rstDone,
  output logic [IDX_W-1:0]  curIdx,
  output logic [IDX_W-1:0]  cfgCount,
  output logic [TMO_W-1:0]  cfgTmo,
  output logic [DATA_W-1:0] statusWord
);

  localparam int RC_W = (RST_LEN > 2) ? $clog2(RST_LEN) : 1;
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_LEN - 1);

  logic [3:0]       cfgKey;
  logic [TMO_W-1:0] runCnt;
  logic [RC_W-1:0]  rstCnt;
  logic             stCmp;
  logic             stFail;
  logic             stTo;
  logic [IDX_W-1:0] stIdx;
  logic             unusedWdataHi;

  assign unusedWdataHi = ^busWdata[DATA_W-1:TMO_W];

  // Configuration registers. They are written only while idle.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      cfgKey   <= '0;
      cfgCount <= '0;
      cfgTmo   <= '0;
    end else if (busWrEn && !busy) begin
      case (busAddr)
        ADDR_CTRL: cfgKey   <= busWdata[3:0];
        ADDR_CNT:  cfgCount <= busWdata[IDX_W-1:0];
        ADDR_TMO:  cfgTmo   <= busWdata[TMO_W-1:0];
        default:   ;
      endcase
    end
  end

  // Interval index, elapsed-cycle counter and reset-length counter.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      curIdx <= '0;
      runCnt <= '0;
      rstCnt <= '0;
    end else if (strobe.startRun) begin
      curIdx <= '0;
      runCnt <= '0;
      rstCnt <= '0;
    end else begin
      if (strobe.advance) curIdx <= curIdx + 1'b1;
      if (strobe.runTick) runCnt <= runCnt + 1'b1;
      if (strobe.rstTick) rstCnt <= rstCnt + 1'b1;
    end
  end

  // Status latch. Only the power-on reset clears it, never the core reset.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      stCmp  <= 1'b0;
      stFail <= 1'b0;
      stTo   <= 1'b0;
      stIdx  <= '0;
    end else begin
      if (strobe.startRun) begin
        stCmp  <= 1'b0;
        stFail <= 1'b0;
        stTo   <= 1'b0;
        stIdx  <= '0;
      end
      if (strobe.latchFail && !stFail) begin
        stFail <= 1'b1;
        stIdx  <= curIdx;
      end
      if (strobe.setComplete) stCmp <= 1'b1;
      if (strobe.setTimeout) begin
        stTo   <= 1'b1;
        stFail <= 1'b1;
      end
    end
  end

  assign keyHit    = busWrEn && (busAddr == ADDR_CTRL) && (busWdata[3:0] == START_KEY);
  assign countZero = (cfgCount == '0);
  assign lastIdx   = (curIdx == cfgCount - 1'b1);
  assign tmoHit    = (({1'b0, runCnt} + 1'b1) >= {1'b0, cfgTmo});
  assign rstDone   = (rstCnt == RC_LAST);

  always_comb begin
    statusWord = '0;
    statusWord[ST_CMP_BIT]  = stCmp;
    statusWord[ST_FAIL_BIT] = stFail;
    statusWord[ST_TO_BIT]   = stTo;
    statusWord[ST_BUSY_BIT] = busy;
    statusWord[ST_IDX_LSB +: IDX_W] = stIdx;
  end

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdata = DATA_W'(cfgKey);
      ADDR_CNT:  busRdata = DATA_W'(cfgCount);
      ADDR_TMO:  busRdata = DATA_W'(cfgTmo);
      default:   busRdata = statusWord;
    endcase
  end

endmodule

// File: rtl/stc_control.sv
`timescale 1ns/1ps
module stc_control
  import stc_pkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       keyHit,
  input  logic       countZero,
  input  logic       lastIdx,
  input  logic       tmoHit,
  input  logic       rstDone,
  input  logic       patDone,
  input  logic       patPass,
  output stcStrobe_t strobe,
  output logic       busy,
  output logic       patStart,
  output logic       coreRstReq
);

  stcState_e state;
  stcState_e stateNext;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) state <= ST_IDLE;
    else          state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (keyHit) begin
          strobe.startRun = 1'b1;
          if (countZero) begin
            strobe.setComplete = 1'b1;
            stateNext = ST_RESET;
          end else begin
            stateNext = ST_LAUNCH;
          end
        end
      end
      ST_LAUNCH: begin
        strobe.runTick = 1'b1;
        if (tmoHit) begin
          strobe.setTimeout = 1'b1;
          stateNext = ST_RESET;
        end else begin
          stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        strobe.runTick = 1'b1;
        if (patDone) begin
          strobe.latchFail = !patPass;
          if (lastIdx) begin
            // A completion wins over a timeout in the same cycle.
            strobe.setComplete = 1'b1;
            stateNext = ST_RESET;
          end else begin
            strobe.advance = 1'b1;
            stateNext = ST_LAUNCH;
          end
        end else if (tmoHit) begin
          strobe.setTimeout = 1'b1;
          stateNext = ST_RESET;
        end
      end
      ST_RESET: begin
        strobe.rstTick = 1'b1;
        if (rstDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy       = (state != ST_IDLE);
  assign patStart   = (state == ST_LAUNCH);
  assign coreRstReq = (state == ST_RESET);

endmodule

// File: rtl/selftest_ctrl.sv
`timescale 1ns/1ps
module selftest_ctrl
  import stc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int TMO_W     = 16,
  parameter int RST_LEN   = 8,
  parameter logic [3:0] START_KEY = 4'hA
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              busWrEn,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              patStart,
  output logic [IDX_W-1:0]  patIdx,
  input  logic              patDone,
  input  logic              patPass,
  output logic              coreRstReq
);

  stcStrobe_t       strobe;
  logic             busy;
  logic             keyHit;
  logic             countZero;
  logic             lastIdx;
  logic             tmoHit;
  logic             rstDone;
  logic [IDX_W-1:0] cfgCount;
  logic [TMO_W-1:0] cfgTmo;
  logic [DATA_W-1:0] statusWord;

  stc_control u_control (
    .clk        (clk),
    .porRstN    (porRstN),
    .keyHit     (keyHit),
    .countZero  (countZero),
    .lastIdx    (lastIdx),
    .tmoHit     (tmoHit),
    .rstDone    (rstDone),
    .patDone    (patDone),
    .patPass    (patPass),
    .strobe     (strobe),
    .busy       (busy),
    .patStart   (patStart),
    .coreRstReq (coreRstReq)
  );

  stc_datapath #(
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .TMO_W     (TMO_W),
    .RST_LEN   (RST_LEN),
    .START_KEY (START_KEY)
  ) u_datapath (
    .clk        (clk),
    .porRstN    (porRstN),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .busy       (busy),
    .strobe     (strobe),
    .keyHit     (keyHit),
    .countZero  (countZero),
    .lastIdx    (lastIdx),
    .tmoHit     (tmoHit),
    .rstDone    (rstDone),
    .curIdx     (patIdx),
    .cfgCount   (cfgCount),
    .cfgTmo     (cfgTmo),
    .statusWord (statusWord)
  );

endmodule

// File: rtl/selftest_ctrl_chk.sv
`timescale 1ns/1ps
module selftest_ctrl_chk #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 5,
  parameter int TMO_W   = 16,
  parameter int RST_LEN = 8
) (
  input logic              clk,
  input logic              porRstN,
  input logic              patStart,
  input logic [IDX_W-1:0]  patIdx,
  input logic              coreRstReq,
  input logic              busy,
  input logic [IDX_W-1:0]  cfgCount,
  input logic [TMO_W-1:0]  cfgTmo,
  input logic [DATA_W-1:0] statusWord
);

  localparam int RL_W = $clog2(RST_LEN + 1) + 1;
  localparam logic [RL_W-1:0] RL_MAX = RL_W'(RST_LEN);

  logic [RL_W-1:0] rstRun;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)        rstRun <= '0;
    else if (coreRstReq) rstRun <= rstRun + 1'b1;
    else                 rstRun <= '0;
  end

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!porRstN)
    patStart |=> !patStart);

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!porRstN)
    patStart |-> (patIdx < cfgCount));

  // R7
  rst_not_long_chk: assert property (@(posedge clk) disable iff (!porRstN)
    coreRstReq |-> (rstRun < RL_MAX));

  // R7
  rst_exact_len_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(coreRstReq) |-> (rstRun == RL_MAX));

  // R7
  rst_no_start_chk: assert property (@(posedge clk) disable iff (!porRstN)
    coreRstReq |-> (!patStart && busy));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (!busy && $past(!busy)) |-> $stable(statusWord));

  // R9
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (busy && $past(busy)) |-> ($stable(cfgCount) && $stable(cfgTmo)));

endmodule

bind selftest_ctrl selftest_ctrl_chk #(
  .DATA_W  (DATA_W),
  .IDX_W   (IDX_W),
  .TMO_W   (TMO_W),
  .RST_LEN (RST_LEN)
) u_chk (
  .clk        (clk),
  .porRstN    (porRstN),
  .patStart   (patStart),
  .patIdx     (patIdx),
  .coreRstReq (coreRstReq),
  .busy       (busy),
  .cfgCount   (cfgCount),
  .cfgTmo     (cfgTmo),
  .statusWord (statusWord)
);

// File: tb/test_selftest_ctrl.sv
`timescale 1ns/1ps
module test_selftest_ctrl;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        patStart;
  logic [4:0]  patIdx;
  logic        patDone = 1'b0;
  logic        patPass = 1'b0;
  logic        coreRstReq;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  selftest_ctrl i_selftest_ctrl (
    .clk        (clk),
    .porRstN    (porRstN),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .patStart   (patStart),
    .patIdx     (patIdx),
    .patDone    (patDone),
    .patPass    (patPass),
    .coreRstReq (coreRstReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finishUp();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Behavioural reference model: phase 0 idle, 1 start, 2 wait, 3 reset.
  int mPhase = 0, mKey = 0, mCnt = 0, mTmo = 0, mCur = 0, mElapsed = 0, mRstCycles = 0;
  int mFailIdx = 0;
  bit mDone = 0, mFail = 0, mTimedOut = 0;

  always @(posedge clk) begin
    if (!porRstN) begin
      mPhase = 0; mKey = 0; mCnt = 0; mTmo = 0; mCur = 0; mElapsed = 0;
      mRstCycles = 0; mFailIdx = 0; mDone = 0; mFail = 0; mTimedOut = 0;
    end else begin
      case (mPhase)
        0: begin
          if (busWrEn) begin
            if (busAddr == 0) mKey = busWdata[3:0];
            if (busAddr == 1) mCnt = busWdata[4:0];
            if (busAddr == 2) mTmo = busWdata[15:0];
            if (busAddr == 0 && busWdata[3:0] == 4'hA) begin
              mDone = 0; mFail = 0; mTimedOut = 0; mFailIdx = 0;
              mCur = 0; mElapsed = 0; mRstCycles = 0;
              if (mCnt == 0) begin mDone = 1; mPhase = 3; end
              else mPhase = 1;
            end
          end
        end
        1: begin
          mElapsed++;
          if (mElapsed >= mTmo) begin mTimedOut = 1; mFail = 1; mPhase = 3; end
          else mPhase = 2;
        end
        2: begin
          mElapsed++;
          if (patDone) begin
            if (!patPass && !mFail) begin mFail = 1; mFailIdx = mCur; end
            if (mCur == mCnt - 1) begin mDone = 1; mPhase = 3; end
            else begin mCur++; mPhase = 1; end
          end else if (mElapsed >= mTmo) begin
            mTimedOut = 1; mFail = 1; mPhase = 3;
          end
        end
        default: begin
          mRstCycles++;
          if (mRstCycles == 8) mPhase = 0;
        end
      endcase
    end
  end

  function automatic logic [31:0] modelRead(input logic [1:0] a);
    logic [31:0] v;
    case (a)
      2'd0: v = 32'(mKey);
      2'd1: v = 32'(mCnt);
      2'd2: v = 32'(mTmo);
      default: v = {19'd0, 5'(mFailIdx), 4'd0, (mPhase != 0), mTimedOut, mFail, mDone};
    endcase
    return v;
  endfunction

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (porRstN) begin
      check("R4 patStart", 32'(patStart), 32'(mPhase == 1));
      check("R4 patIdx", 32'(patIdx), 32'(mCur));
      check("R7 coreRstReq", 32'(coreRstReq), 32'(mPhase == 3));
      if (busAddr == 2'd3) check("R8 status read", busRdata, modelRead(busAddr));
      else                 check("R3 config read", busRdata, modelRead(busAddr));
    end
  end

  // Pattern engine stand-in.
  int respWait = -1;
  int respDelay = 2;
  logic [31:0] failMask = '0;
  int engIdx = 0;
  always @(negedge clk) begin
    #1;
    patDone = 1'b0;
    if (respWait == 0) begin
      patDone = 1'b1;
      patPass = !failMask[engIdx];
      respWait = -1;
    end else if (respWait > 0) begin
      respWait--;
    end
    if (patStart) begin
      engIdx = patIdx;
      respWait = respDelay;
    end
  end

  // Port observers for the directed checks.
  int nStarts = 0;
  int rstRunLen = 0;
  int lastRstLen = 0;
  always @(negedge clk) begin
    if (patStart) nStarts++;
    if (coreRstReq) rstRunLen++;
    else if (rstRunLen != 0) begin lastRstLen = rstRunLen; rstRunLen = 0; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
      finishUp();
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    busAddr = a;
    @(negedge clk);
    d = busRdata;
  endtask

  task automatic waitIdle();
    @(negedge clk); #1;
    busAddr = 2'd3;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (busRdata[3] == 1'b0) break;
    end
  endtask

  task automatic clearObs();
    @(posedge clk);
    nStarts = 0;
    lastRstLen = 0;
  endtask

  task automatic cancelEngine();
    @(posedge clk);
    respWait = -1;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #1 porRstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset register", v, 32'd0);
    end
    check("R1 patStart low", 32'(patStart), 32'd0);
    check("R1 coreRstReq low", 32'(coreRstReq), 32'd0);

    // R3: configuration readback
    wr(2'd1, 32'd4);
    wr(2'd2, 32'd200);
    rd(2'd1, v); check("R3 count readback", v, 32'd4);
    rd(2'd2, v); check("R3 timeout readback", v, 32'd200);

    // R2: wrong key leaves the block idle
    clearObs();
    wr(2'd0, 32'h5);
    repeat (3) @(negedge clk);
    rd(2'd3, v); check("R2 wrong key stays idle", v, 32'd0);
    rd(2'd0, v); check("R3 key readback", v, 32'h5);
    check("R2 no start pulses", 32'(nStarts), 32'd0);

    // Passing run, with writes attempted while busy
    respDelay = 2; failMask = '0;
    clearObs();
    wr(2'd0, 32'hA);
    wr(2'd1, 32'd7);
    wr(2'd2, 32'd3);
    rd(2'd3, v); check("R9 status readable while busy", 32'(v[3]), 32'd1);
    waitIdle();
    rd(2'd3, v); check("R8 pass status", v, 32'h1);
    check("R4 four intervals", 32'(nStarts), 32'd4);
    check("R7 reset pulse length", 32'(lastRstLen), 32'd8);
    rd(2'd1, v); check("R9 count unchanged", v, 32'd4);
    rd(2'd2, v); check("R9 timeout unchanged", v, 32'd200);

    // R5: first failing interval wins
    failMask = 32'b1010;
    wr(2'd0, 32'hA);
    waitIdle();
    rd(2'd3, v); check("R5 first fail index", v, 32'h103);

    // R6: hung engine hits the timeout
    failMask = '0; respDelay = 1000;
    wr(2'd2, 32'd20);
    wr(2'd0, 32'hA);
    waitIdle();
    rd(2'd3, v); check("R6 timeout status", v, 32'h6);
    cancelEngine();

    // R4: zero intervals; R8: a new start clears the old status
    respDelay = 2;
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd200);
    clearObs();
    wr(2'd0, 32'hA);
    waitIdle();
    rd(2'd3, v); check("R8 start clears status", v, 32'h1);
    check("R4 zero intervals", 32'(nStarts), 32'd0);
    check("R7 reset pulse zero count", 32'(lastRstLen), 32'd8);

    // R10: completion and expiry in the same cycle
    respDelay = 0;
    wr(2'd1, 32'd1);
    wr(2'd2, 32'd2);
    wr(2'd0, 32'hA);
    waitIdle();
    rd(2'd3, v); check("R10 completion wins", v, 32'h1);
    wr(2'd2, 32'd1);
    wr(2'd0, 32'hA);
    waitIdle();
    rd(2'd3, v); check("R6 one-cycle budget", v, 32'h6);
    cancelEngine();

    // R1: only the power-on reset clears the status
    @(negedge clk); #1 porRstN = 1'b0;
    repeat (2) @(negedge clk);
    #1 porRstN = 1'b1;
    rd(2'd3, v); check("R1 status after power-on reset", v, 32'd0);

    repeat (4) @(negedge clk);
    finishUp();
  end

endmodule